// File: doc/BRIEF.md
# USB Host Transaction Launch Controller

This block holds the per-channel setup for host-side USB transactions and hands each armed transaction to a serial interface engine. Each channel has three 16-bit registers: control, buffer pointer and count. Firmware fills the pointer and count, then writes the control word with the arm bit set.

Once armed, the channel waits until two things are true. Its engine must report idle. If frame synchronisation is requested, a sync event must also be seen: a start-of-frame strobe at full speed, or a keep-alive end-of-packet strobe at low speed. The channel then emits a one-cycle start request. That request carries a snapshot of the pointer, count, port select, data toggle and isochronous flag, and the snapshot holds until the engine signals done. The done signal drops the arm bit.

Sequence checking of received data is not done here. The toggle bit only picks the PID of the next transmitted data packet. The engine itself and packet encoding lie outside the block.

Top module: `usb_hxfer_launch`

## Requirements
- R1: After reset every register of every channel reads 0, arm reads 0 and no start request is issued.
- R2: The pointer register, at channel offset +2, is a 16-bit read/write value that reads back exactly what was written.
- R3: In the count register, at channel offset +4, bit 14 is the port select and bits 9:0 are the byte count. All other bits read 0, and writes to them are ignored.
- R4: In the control register, at channel offset +0, bit 6 is the data toggle (1 = DATA1, 0 = DATA0), bit 5 is sync enable, bit 4 is isochronous and bit 0 is arm. All other bits read 0.
- R5: With sync enable 0, an armed channel pulses start for exactly one cycle. The pulse comes one cycle after the first armed cycle in which its engine-idle input is 1, and it never comes while engine-idle is 0.
- R6: With sync enable 1 at full speed (low-speed input 0), launch waits for a start-of-frame strobe seen while armed. The end-of-packet strobe has no effect.
- R7: With sync enable 1 at low speed (low-speed input 1), launch waits for an end-of-packet strobe seen while armed. The start-of-frame strobe has no effect.
- R8: The request pointer, count, port select, toggle and iso outputs equal the register values at launch. They stay unchanged until done, even when the registers are rewritten.
- R9: Arm reads 1 from the write that sets it until the cycle after done is seen on a launched transaction. It then reads 0.
- R10: Writing arm=1 while a transaction is launched produces no second start. Done is ignored when no transaction is launched.
- R11: Writing the control register with arm=0 before launch cancels the transaction, and no start follows.
- R12: Channel n's registers sit at byte offset n*0x20. The channels operate independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Byte address of register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| eng_idle_i | input | 2 | Per-channel engine free |
| eng_done_i | input | 2 | Per-channel transaction complete |
| low_speed_i | input | 2 | Per-channel speed: 1 selects the end-of-packet strobe as sync event |
| sof_i | input | 2 | Per-channel start-of-frame sent strobe |
| eop_i | input | 2 | Per-channel keep-alive end-of-packet sent strobe |
| start_o | output | 2 | Per-channel one-cycle start request |
| req_ptr_o | output | 32 | Per-channel buffer pointer, 16 bits each |
| req_cnt_o | output | 20 | Per-channel byte count, 10 bits each |
| req_psel_o | output | 2 | Per-channel port select |
| req_tog_o | output | 2 | Per-channel data toggle (1 = DATA1) |
| req_iso_o | output | 2 | Per-channel isochronous flag |

## Verification
The bench builds the block with its default parameters: two channels, a 6-bit byte address and a 10-bit count. That puts the second channel at offset 0x20 within reach, so channel independence and concurrent launches can be exercised. A behavioural per-channel model follows arm, cancel, sync-event and done. Every cycle, the model is compared with the start pulses and the held request fields.

// File: rtl/hl_pkg.sv
package hl_pkg;
  localparam int REG_W      = 16;
  localparam int BIT_TOG    = 6;
  localparam int BIT_SYNC   = 5;
  localparam int BIT_ISO    = 4;
  localparam int BIT_ARM    = 0;
  localparam int BIT_PSEL   = 14;
  localparam int OFF_CTRL   = 0;
  localparam int OFF_PTR    = 2;
  localparam int OFF_CNT    = 4;

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_PTR, SEL_CNT} reg_sel_e;
  typedef enum logic [1:0] {CH_IDLE, CH_WAIT, CH_BUSY} ch_state_e;
endpackage

// File: rtl/hl_bus_decode.sv
module hl_bus_decode
  import hl_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int ADDR_W      = 6,
  parameter int STRIDE_LOG2 = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NCH-1:0]    ch_hit_o,
  output reg_sel_e          reg_sel_o
);
  localparam int IDX_W = ADDR_W - STRIDE_LOG2;

  logic [IDX_W-1:0]       idx;
  logic [STRIDE_LOG2-1:0] off;

  assign idx = addr_i[ADDR_W-1:STRIDE_LOG2];
  assign off = addr_i[STRIDE_LOG2-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign ch_hit_o[g] = (idx == IDX_W'(g));
  end

  always_comb begin
    if (off == STRIDE_LOG2'(OFF_CTRL))     reg_sel_o = SEL_CTRL;
    else if (off == STRIDE_LOG2'(OFF_PTR)) reg_sel_o = SEL_PTR;
    else if (off == STRIDE_LOG2'(OFF_CNT)) reg_sel_o = SEL_CNT;
    else                                   reg_sel_o = SEL_NONE;
  end
endmodule

// File: rtl/hl_chan.sv
module hl_chan
  import hl_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             eng_idle_i,
  input  logic             done_i,
  input  logic             low_speed_i,
  input  logic             sof_i,
  input  logic             eop_i,
  output logic             start_o,
  output logic [PTR_W-1:0] req_ptr_o,
  output logic [CNT_W-1:0] req_cnt_o,
  output logic             req_psel_o,
  output logic             req_tog_o,
  output logic             req_iso_o
);
  ch_state_e        state_q, state_d;
  logic             seen_q, seen_d;
  logic             start_q;
  logic             tog_q, sync_q, iso_q, psel_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cap_tog_q, cap_iso_q, cap_psel_q;
  logic [PTR_W-1:0] cap_ptr_q;
  logic [CNT_W-1:0] cap_cnt_q;

  logic wr_ctrl, wr_ptr, wr_cnt, evt, cancel, launch;

  assign wr_ctrl = wr_i && (sel_i == SEL_CTRL);
  assign wr_ptr  = wr_i && (sel_i == SEL_PTR);
  assign wr_cnt  = wr_i && (sel_i == SEL_CNT);
  assign evt     = low_speed_i ? eop_i : sof_i;
  assign cancel  = (state_q == CH_WAIT) && wr_ctrl && !wdata_i[BIT_ARM];
  assign launch  = (state_q == CH_WAIT) && !cancel && eng_idle_i &&
                   (!sync_q || seen_q || evt);

  always_comb begin
    state_d = state_q;
    seen_d  = seen_q;
    unique case (state_q)
      CH_IDLE: if (wr_ctrl && wdata_i[BIT_ARM]) begin
        state_d = CH_WAIT;
        seen_d  = 1'b0;
      end
      CH_WAIT: begin
        if (cancel)      state_d = CH_IDLE;
        else if (launch) state_d = CH_BUSY;
        else if (evt)    seen_d  = 1'b1;
      end
      CH_BUSY: if (done_i) state_d = CH_IDLE;
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      seen_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
      start_q <= launch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      sync_q <= 1'b0;
      iso_q  <= 1'b0;
      ptr_q  <= '0;
      cnt_q  <= '0;
      psel_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        tog_q  <= wdata_i[BIT_TOG];
        sync_q <= wdata_i[BIT_SYNC];
        iso_q  <= wdata_i[BIT_ISO];
      end
      if (wr_ptr) ptr_q <= wdata_i[PTR_W-1:0];
      if (wr_cnt) begin
        cnt_q  <= wdata_i[CNT_W-1:0];
        psel_q <= wdata_i[BIT_PSEL];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_tog_q  <= 1'b0;
      cap_iso_q  <= 1'b0;
      cap_psel_q <= 1'b0;
      cap_ptr_q  <= '0;
      cap_cnt_q  <= '0;
    end else if (launch) begin
      cap_tog_q  <= tog_q;
      cap_iso_q  <= iso_q;
      cap_psel_q <= psel_q;
      cap_ptr_q  <= ptr_q;
      cap_cnt_q  <= cnt_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_CTRL: begin
        rdata_o[BIT_TOG]  = tog_q;
        rdata_o[BIT_SYNC] = sync_q;
        rdata_o[BIT_ISO]  = iso_q;
        rdata_o[BIT_ARM]  = (state_q != CH_IDLE);
      end
      SEL_PTR: rdata_o[PTR_W-1:0] = ptr_q;
      SEL_CNT: begin
        rdata_o[CNT_W-1:0] = cnt_q;
        rdata_o[BIT_PSEL]  = psel_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign start_o    = start_q;
  assign req_ptr_o  = cap_ptr_q;
  assign req_cnt_o  = cap_cnt_q;
  assign req_psel_o = cap_psel_q;
  assign req_tog_o  = cap_tog_q;
  assign req_iso_o  = cap_iso_q;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R5
  AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(eng_idle_i)); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_BUSY && !start_o) |->
      $stable({req_ptr_o, req_cnt_o, req_psel_o, req_tog_o, req_iso_o})); // R8
  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_BUSY && done_i) |=> (state_q == CH_IDLE && !start_o)); // R9
  AST_NO_START_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && state_q == CH_BUSY) |=> (state_q != CH_BUSY || !start_o)); // R10
endmodule

// File: rtl/usb_hxfer_launch.sv
module usb_hxfer_launch
  import hl_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int ADDR_W      = 6,
  parameter int STRIDE_LOG2 = 5,
  parameter int PTR_W       = 16,
  parameter int CNT_W       = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [REG_W-1:0]     bus_wdata_i,
  output logic [REG_W-1:0]     bus_rdata_o,
  input  logic [NCH-1:0]       eng_idle_i,
  input  logic [NCH-1:0]       eng_done_i,
  input  logic [NCH-1:0]       low_speed_i,
  input  logic [NCH-1:0]       sof_i,
  input  logic [NCH-1:0]       eop_i,
  output logic [NCH-1:0]       start_o,
  output logic [NCH*PTR_W-1:0] req_ptr_o,
  output logic [NCH*CNT_W-1:0] req_cnt_o,
  output logic [NCH-1:0]       req_psel_o,
  output logic [NCH-1:0]       req_tog_o,
  output logic [NCH-1:0]       req_iso_o
);
  logic [NCH-1:0]   ch_hit;
  reg_sel_e         reg_sel;
  logic [REG_W-1:0] ch_rd [NCH];

  hl_bus_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2)) u_dec (
    .addr_i   (bus_addr_i),
    .ch_hit_o (ch_hit),
    .reg_sel_o(reg_sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hl_chan #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr_i && ch_hit[c]),
      .sel_i      (reg_sel),
      .wdata_i    (bus_wdata_i),
      .rdata_o    (ch_rd[c]),
      .eng_idle_i (eng_idle_i[c]),
      .done_i     (eng_done_i[c]),
      .low_speed_i(low_speed_i[c]),
      .sof_i      (sof_i[c]),
      .eop_i      (eop_i[c]),
      .start_o    (start_o[c]),
      .req_ptr_o  (req_ptr_o[c*PTR_W +: PTR_W]),
      .req_cnt_o  (req_cnt_o[c*CNT_W +: CNT_W]),
      .req_psel_o (req_psel_o[c]),
      .req_tog_o  (req_tog_o[c]),
      .req_iso_o  (req_iso_o[c])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_hit[c]) bus_rdata_o = bus_rdata_o | ch_rd[c];
    end
  end
endmodule

// File: tb/usb_hxfer_launch_tb.sv
module usb_hxfer_launch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  eng_idle = '0, eng_done = '0, low_speed = '0, sof = '0, eop = '0;
  logic [1:0]  start, req_psel, req_tog, req_iso;
  logic [31:0] req_ptr;
  logic [19:0] req_cnt;

  int checks = 0, errors = 0;
  int n_start [2] = '{0, 0};

  int m_st [2], m_seen [2], m_start [2];
  int m_tog [2], m_sync [2], m_iso [2], m_psel [2], m_ptr [2], m_cnt [2];
  int c_tog [2], c_iso [2], c_psel [2], c_ptr [2], c_cnt [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_hxfer_launch dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .eng_idle_i(eng_idle),
    .eng_done_i(eng_done), .low_speed_i(low_speed), .sof_i(sof), .eop_i(eop),
    .start_o(start), .req_ptr_o(req_ptr), .req_cnt_o(req_cnt),
    .req_psel_o(req_psel), .req_tog_o(req_tog), .req_iso_o(req_iso)
  );

  // Reference model, advanced on the same edge from the same inputs
  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      int w, ev, wc, wp, wn;
      w  = bus_wr && (bus_addr[5] == c[0]);
      wc = w && bus_addr[4:0] == 0;
      wp = w && bus_addr[4:0] == 2;
      wn = w && bus_addr[4:0] == 4;
      ev = low_speed[c] ? eop[c] : sof[c];
      m_start[c] = 0;
      if (!rst_n) begin
        m_st[c] = 0; m_seen[c] = 0; m_tog[c] = 0; m_sync[c] = 0; m_iso[c] = 0;
        m_psel[c] = 0; m_ptr[c] = 0; m_cnt[c] = 0;
      end else begin
        if (m_st[c] == 0) begin
          if (wc && bus_wdata[0]) begin m_st[c] = 1; m_seen[c] = 0; end
        end else if (m_st[c] == 1) begin
          if (wc && !bus_wdata[0]) m_st[c] = 0;
          else if (eng_idle[c] && (m_sync[c] == 0 || m_seen[c] != 0 || ev != 0)) begin
            m_st[c] = 2; m_start[c] = 1;
            c_tog[c] = m_tog[c]; c_iso[c] = m_iso[c]; c_psel[c] = m_psel[c];
            c_ptr[c] = m_ptr[c]; c_cnt[c] = m_cnt[c];
          end else if (ev != 0) m_seen[c] = 1;
        end else if (eng_done[c]) m_st[c] = 0;
        if (wc) begin
          m_tog[c] = bus_wdata[6]; m_sync[c] = bus_wdata[5]; m_iso[c] = bus_wdata[4];
        end
        if (wp) m_ptr[c] = bus_wdata;
        if (wn) begin m_cnt[c] = bus_wdata[9:0]; m_psel[c] = bus_wdata[14]; end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (start[c]) n_start[c]++;
        chk($sformatf("R5 ch%0d start", c), int'(start[c]), m_start[c]);
        if (m_st[c] == 2) begin
          chk($sformatf("R8 ch%0d ptr", c), int'(req_ptr[c*16 +: 16]), c_ptr[c]);
          chk($sformatf("R8 ch%0d cnt", c), int'(req_cnt[c*10 +: 10]), c_cnt[c]);
          chk($sformatf("R8 ch%0d flags", c), int'({req_psel[c], req_tog[c], req_iso[c]}),
              (c_psel[c] << 2) | (c_tog[c] << 1) | c_iso[c]);
        end
      end
    end
  end

  function automatic int exp_rd(input int c, input int off);
    if (off == 0) return (m_tog[c] << 6) | (m_sync[c] << 5) | (m_iso[c] << 4) | int'(m_st[c] != 0);
    if (off == 2) return m_ptr[c];
    if (off == 4) return (m_psel[c] << 14) | m_cnt[c];
    return 0;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = 16'(d);
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input int a, input int exp);
    @(negedge clk); #1;
    bus_addr = 6'(a); #1;
    chk(req, int'(bus_rdata), exp);
    chk({req, " model"}, int'(bus_rdata), exp_rd(a >> 5, a & 31));
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic [1:0] sig, input int c);
    @(negedge clk); #1; sig[c] = 1'b1;
    @(negedge clk); #1; sig[c] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    for (int c = 0; c < 2; c++) begin
      rd("R1 ctrl", c*32 + 0, 0);
      rd("R1 ptr",  c*32 + 2, 0);
      rd("R1 cnt",  c*32 + 4, 0);
    end
    chk("R1 no start", int'(start), 0);
    // R2, R12 pointer registers per channel
    wr(2, 16'hBEEF);
    wr(32 + 2, 16'h1234);
    rd("R2 ch0 ptr", 2, 16'hBEEF);
    rd("R12 ch1 ptr", 32 + 2, 16'h1234);
    // R3 count register masking
    wr(4, 16'hFFFF);
    rd("R3 cnt mask", 4, 16'h43FF);
    wr(4, 16'h0155);
    rd("R3 cnt value", 4, 16'h0155);
    // R4 control masking, arm bit left clear
    wr(0, 16'hFF7E);
    rd("R4 ctrl mask", 0, 16'h0070);
    wr(0, 0);
    rd("R4 ctrl clear", 0, 0);
    // R5 launch waits for engine idle
    wr(0, 16'h0041);
    idle_cycles(5);
    chk("R5 no start while busy engine", n_start[0], 0);
    rd("R9 arm set", 0, 16'h0041);
    @(negedge clk); #1; eng_idle[0] = 1'b1;
    idle_cycles(3);
    chk("R5 single start", n_start[0], 1);
    chk("R4 toggle DATA1", int'(req_tog[0]), 1);
    // R8 rewrite registers in flight
    wr(2, 16'h5555);
    wr(4, 16'h4003);
    wr(0, 16'h0011);
    chk("R8 ptr held", int'(req_ptr[15:0]), 16'hBEEF);
    chk("R8 cnt held", int'(req_cnt[9:0]), 16'h155);
    // R10 arm rewrite during flight gives no new start
    idle_cycles(3);
    chk("R10 no restart", n_start[0], 1);
    pulse(eng_done, 0);
    rd("R9 arm cleared", 0, 16'h0010);
    pulse(eng_done, 0);
    rd("R10 stray done", 0, 16'h0010);
    chk("R10 start count", n_start[0], 1);
    // R6 full-speed sync: eop ignored, sof launches
    wr(0, 16'h0021);
    idle_cycles(3);
    pulse(eop, 0);
    idle_cycles(2);
    chk("R6 eop ignored", n_start[0], 1);
    pulse(sof, 0);
    idle_cycles(2);
    chk("R6 sof launches", n_start[0], 2);
    chk("R8 new ptr", int'(req_ptr[15:0]), 16'h5555);
    pulse(eng_done, 0);
    // R7 low-speed sync: sof ignored, eop launches
    @(negedge clk); #1; low_speed[0] = 1'b1;
    wr(0, 16'h0031);
    pulse(sof, 0);
    idle_cycles(2);
    chk("R7 sof ignored", n_start[0], 2);
    pulse(eop, 0);
    idle_cycles(2);
    chk("R7 eop launches", n_start[0], 3);
    chk("R7 iso flag", int'(req_iso[0]), 1);
    pulse(eng_done, 0);
    // R11 cancel before launch
    @(negedge clk); #1; eng_idle[0] = 1'b0;
    wr(0, 16'h0001);
    wr(0, 16'h0000);
    rd("R11 arm dropped", 0, 0);
    @(negedge clk); #1; eng_idle[0] = 1'b1;
    idle_cycles(4);
    chk("R11 no start", n_start[0], 3);
    // R10 done while waiting is ignored
    @(negedge clk); #1; eng_idle[0] = 1'b0;
    wr(0, 16'h0001);
    pulse(eng_done, 0);
    rd("R10 done ignored in wait", 0, 16'h0001);
    // R12 both channels launch independently
    @(negedge clk); #1; eng_idle = 2'b11;
    wr(32 + 4, 16'h4200);
    wr(32 + 0, 16'h0041);
    idle_cycles(3);
    chk("R12 ch1 start", n_start[1], 1);
    chk("R12 ch0 start", n_start[0], 4);
    chk("R12 ch1 ptr", int'(req_ptr[31:16]), 16'h1234);
    chk("R12 ch1 psel", int'(req_psel[1]), 1);
    s0 = n_start[0];
    pulse(eng_done, 1);
    rd("R12 ch1 disarmed", 32, 16'h0040);
    rd("R12 ch0 still armed", 0, 16'h0001);
    chk("R12 ch0 unaffected", n_start[0], s0);
    pulse(eng_done, 0);
    idle_cycles(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule